// File: doc/BRIEF.md
# Local Vector Table Register File

This block holds the configuration words for the local interrupt sources of an interrupt controller: timer, thermal sensor, performance counter, the two local interrupt pins, internal error, and an optional corrected-machine-check source. Software reaches the words through a simple request/write-enable bus with a 12-bit byte offset and 32-bit data. Each write is trimmed to the bits that entry may hold. The mask bit is forced on at reset, on every write while the controller is software-disabled, and on all entries at the moment software clears the enable bit in the spurious-vector register.

The corrected-machine-check entry is built in hardware, but it is only reachable when the capability input was high during reset. Six regular entries sit on a 0x10 stride from offset 0x320. The optional seventh sits apart at 0x2F0. A read-only version word tells software how many entries are present. Read data and an invalid-access flag come out registered, one cycle after the request.

Top module: `lvt_regbank`

## Requirements
- R1: After reset every entry reads 0x00010000 (only the mask bit, bit 16, set) and the spurious-vector register at 0x0F0 reads 0.
- R2: The version word at 0x030 reads the implemented entry count minus one in bits 23:16 and VER_CODE (default 0x14) in bits 7:0: 0x00060014 with the capability, 0x00050014 without it. Writes to it change nothing.
- R3: Entry i (0 timer, 1 thermal, 2 performance, 3 pin 0, 4 pin 1, 5 error) lives at 0x320 + 0x10·i. The corrected-machine-check entry lives at 0x2F0.
- R4: A write is ANDed with the entry's writable mask: timer 0x000700FF, thermal and error 0x000100FF, performance and corrected-machine-check 0x000107FF, both pin entries 0x0001A7FF. No entry ever holds a bit outside its mask.
- R5: While the enable bit (bit 8 of 0x0F0) is clear, a write to an entry is stored with bit 16 set. While it is set, bit 16 is stored as written.
- R6: A write to 0x0F0 with bit 8 clear sets bit 16 in every entry and keeps every other bit of each entry.
- R7: Without the capability, a write to 0x2F0 stores nothing and raises bad_o. A read of 0x2F0 returns 0 and raises bad_o.
- R8: A request to an offset that maps to no register, or that is not 16-byte aligned, raises bad_o and changes no register. If it is a read, it returns 0.
- R9: rdata_o and bad_o follow the request by exactly one cycle. bad_o stays low in any cycle that follows a cycle without a request.
- R10: The capability input is taken only while reset is held. Changing it afterwards alters neither the version word nor the reachability of 0x2F0.
- R11: Register 0x0F0 keeps bits 8:0 of a write and reads them back with the upper bits zero. Setting the enable bit leaves the entries unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmc_cap_i | input | 1 | Corrected-machine-check capability, taken during reset |
| req_i | input | 1 | Bus request, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| bad_o | output | 1 | Invalid or refused access, one cycle after the request |

## Verification
The checker watches several things on every cycle: the writable-mask invariant of every entry, the forced mask bits after a disabling write to the spurious register, the refusal of the absent corrected-machine-check entry, the entry count in the version word, zero data on invalid reads, and the frozen capability. Other behaviours can only be shown by the directed scenarios. These are the exact reset contents, the address-to-entry mapping, the preservation of the other bits when masking, the forced mask on writes while disabled, and the lack of side effects from invalid and version writes.

// File: rtl/lvt_pkg.sv
package lvt_pkg;
  localparam int unsigned LVT_W      = 32;
  localparam int unsigned LVT_AW     = 12;
  localparam int unsigned LVT_MAX    = 7;
  localparam int unsigned LVT_REG_N  = LVT_MAX - 1;
  localparam int unsigned LVT_IDX_W  = $clog2(LVT_MAX);
  localparam int unsigned CMC_IDX    = LVT_MAX - 1;
  localparam int unsigned MASK_BIT   = 16;
  localparam int unsigned SVR_EN_BIT = 8;
  localparam int unsigned SVR_W      = SVR_EN_BIT + 1;

  localparam logic [LVT_AW-1:0] OFF_VER  = 12'h030;
  localparam logic [LVT_AW-1:0] OFF_SVR  = 12'h0F0;
  localparam logic [LVT_AW-1:0] OFF_CMC  = 12'h2F0;
  localparam logic [LVT_AW-1:0] OFF_LVT0 = 12'h320;

  localparam logic [LVT_W-1:0] F_VEC   = 32'h0000_00FF;
  localparam logic [LVT_W-1:0] F_MODE  = 32'h0000_0700;
  localparam logic [LVT_W-1:0] F_POL   = 32'h0000_2000;
  localparam logic [LVT_W-1:0] F_TRIG  = 32'h0000_8000;
  localparam logic [LVT_W-1:0] F_MASK  = 32'h0001_0000;
  localparam logic [LVT_W-1:0] F_TMODE = 32'h0006_0000;

  typedef enum logic [LVT_IDX_W-1:0] {
    ENT_TIMER, ENT_THERM, ENT_PERF, ENT_PIN0, ENT_PIN1, ENT_ERR, ENT_CMC
  } ent_e;

  typedef struct packed {
    logic                 hit_ent;
    logic [LVT_IDX_W-1:0] idx;
    logic                 hit_ver;
    logic                 hit_svr;
    logic                 bad;
  } dec_t;

  function automatic logic [LVT_W-1:0] wr_mask(input int unsigned idx);
    logic [LVT_W-1:0] m;
    m = F_VEC | F_MASK;
    case (ent_e'(idx))
      ENT_TIMER:         m = m | F_TMODE;
      ENT_PERF, ENT_CMC: m = m | F_MODE;
      ENT_PIN0, ENT_PIN1: m = m | F_MODE | F_POL | F_TRIG;
      default:           m = m;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/lvt_decode.sv
module lvt_decode
  import lvt_pkg::*;
(
  input  logic [LVT_AW-1:0] addr_i,
  input  logic              cmc_present_i,
  output dec_t              dec_o
);
  localparam logic [7:0] LINE0   = OFF_LVT0[11:4];
  localparam logic [7:0] LINE_END = LINE0 + 8'(LVT_REG_N);

  logic [7:0] line;
  assign line = addr_i[11:4];

  always_comb begin
    dec_o = '0;
    if (addr_i[3:0] == 4'h0) begin
      if (line >= LINE0 && line < LINE_END) begin
        dec_o.hit_ent = 1'b1;
        dec_o.idx     = LVT_IDX_W'(line - LINE0);
      end else if (line == OFF_CMC[11:4] && cmc_present_i) begin
        dec_o.hit_ent = 1'b1;
        dec_o.idx     = LVT_IDX_W'(CMC_IDX);
      end else if (line == OFF_VER[11:4]) begin
        dec_o.hit_ver = 1'b1;
      end else if (line == OFF_SVR[11:4]) begin
        dec_o.hit_svr = 1'b1;
      end
    end
    dec_o.bad = !(dec_o.hit_ent || dec_o.hit_ver || dec_o.hit_svr);
  end
endmodule

// File: rtl/lvt_entry.sv
module lvt_entry
  import lvt_pkg::*;
#(
  parameter int unsigned IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [LVT_W-1:0] wdata_i,
  input  logic             sw_en_i,
  input  logic             mask_all_i,
  output logic [LVT_W-1:0] q_o
);
  localparam logic [LVT_W-1:0] WMASK = wr_mask(IDX);

  logic [LVT_W-1:0] q_q, q_n;
  logic             q_en;

  always_comb begin
    q_n  = q_q;
    q_en = 1'b0;
    if (wr_i) begin
      q_en = 1'b1;
      q_n  = (wdata_i | (sw_en_i ? '0 : F_MASK)) & WMASK;
    end else if (mask_all_i) begin
      q_en = 1'b1;
      q_n  = q_q | F_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= F_MASK;
    else if (q_en) q_q <= q_n;
  end

  assign q_o = q_q;
endmodule

// File: rtl/lvt_rdmux.sv
module lvt_rdmux
  import lvt_pkg::*;
#(
  parameter logic [7:0] VER_CODE = 8'h14
) (
  input  dec_t                        dec_i,
  input  logic [LVT_MAX-1:0][LVT_W-1:0] ent_i,
  input  logic                        cmc_present_i,
  input  logic [SVR_W-1:0]            svr_i,
  output logic [LVT_W-1:0]            rd_o
);
  logic [LVT_W-1:0] ent_sel;
  logic [7:0]       cnt_m1;

  always_comb begin
    ent_sel = '0;
    for (int i = 0; i < LVT_MAX; i++) begin
      if (dec_i.idx == LVT_IDX_W'(i)) ent_sel = ent_i[i];
    end
  end

  assign cnt_m1 = cmc_present_i ? 8'(LVT_MAX - 1) : 8'(LVT_MAX - 2);

  always_comb begin
    rd_o = '0;
    if (dec_i.hit_ent)      rd_o = ent_sel;
    else if (dec_i.hit_ver) rd_o = {8'h00, cnt_m1, 8'h00, VER_CODE};
    else if (dec_i.hit_svr) rd_o = LVT_W'(svr_i);
  end
endmodule

// File: rtl/lvt_regbank.sv
module lvt_regbank
  import lvt_pkg::*;
#(
  parameter logic [7:0] VER_CODE = 8'h14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmc_cap_i,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [11:0] addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        bad_o
);
  dec_t                          dec;
  logic                          cmc_q;
  logic [LVT_MAX-1:0][LVT_W-1:0] ent_q;
  logic [SVR_W-1:0]              svr_q, svr_n;
  logic                          svr_en;
  logic                          ent_wr, mask_all;
  logic [LVT_W-1:0]              rd_mux;
  logic [LVT_W-1:0]              rdata_q, rdata_n;
  logic                          rd_en;
  logic                          bad_q, bad_n;

  // Capability register: loaded on clock edges seen while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) cmc_q <= cmc_cap_i;
  end

  lvt_decode u_dec (
    .addr_i        (addr_i),
    .cmc_present_i (cmc_q),
    .dec_o         (dec)
  );

  assign ent_wr   = req_i && we_i && dec.hit_ent;
  assign svr_en   = req_i && we_i && dec.hit_svr;
  assign mask_all = svr_en && !wdata_i[SVR_EN_BIT];

  for (genvar g = 0; g < LVT_MAX; g++) begin : g_ent
    lvt_entry #(.IDX(g)) u_ent (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (ent_wr && (dec.idx == LVT_IDX_W'(g))),
      .wdata_i    (wdata_i),
      .sw_en_i    (svr_q[SVR_EN_BIT]),
      .mask_all_i (mask_all),
      .q_o        (ent_q[g])
    );
  end

  assign svr_n = wdata_i[SVR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      svr_q <= '0;
    else if (svr_en) svr_q <= svr_n;
  end

  lvt_rdmux #(.VER_CODE(VER_CODE)) u_rd (
    .dec_i         (dec),
    .ent_i         (ent_q),
    .cmc_present_i (cmc_q),
    .svr_i         (svr_q),
    .rd_o          (rd_mux)
  );

  assign rd_en   = req_i && !we_i;
  assign rdata_n = dec.bad ? '0 : rd_mux;
  assign bad_n   = req_i && dec.bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bad_q <= 1'b0;
    else        bad_q <= bad_n;
  end

  assign rdata_o = rdata_q;
  assign bad_o   = bad_q;
endmodule

// File: rtl/lvt_regbank_chk.sv
module lvt_regbank_chk
  import lvt_pkg::*;
(
  input logic                          clk,
  input logic                          rst_n,
  input logic                          req_i,
  input logic                          we_i,
  input logic [11:0]                   addr_i,
  input logic                          wen_bit,
  input logic [31:0]                   rdata_o,
  input logic                          bad_o,
  input logic                          cmc_q,
  input logic [LVT_MAX-1:0][LVT_W-1:0] ent_q
);
  logic [LVT_MAX-1:0] mbits;
  always_comb begin
    for (int i = 0; i < LVT_MAX; i++) mbits[i] = ent_q[i][MASK_BIT];
  end

  for (genvar g = 0; g < LVT_MAX; g++) begin : g_inv
    assert_within_wmask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_q[g] & ~wr_mask(g)) == '0);
  end

  assert_disable_masks_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && we_i && addr_i == OFF_SVR && !wen_bit) |=> (&mbits));

  assert_absent_cmc_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && we_i && addr_i == OFF_CMC && !cmc_q) |=> bad_o);

  assert_version_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !we_i && addr_i == OFF_VER) |=> rdata_o[23:16] == (cmc_q ? 8'd6 : 8'd5));

  assert_bad_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !we_i) |=> (!bad_o || rdata_o == '0));

  assert_no_spurious_bad_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !bad_o);

  assert_cap_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(cmc_q));
endmodule

bind lvt_regbank lvt_regbank_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wen_bit (wdata_i[8]),
  .rdata_o (rdata_o),
  .bad_o   (bad_o),
  .cmc_q   (cmc_q),
  .ent_q   (ent_q)
);

// File: tb/lvt_regbank_bench.sv
module lvt_regbank_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmc_cap_i;
  logic        req_i;
  logic        we_i;
  logic [11:0] addr_i;
  logic [31:0] wdata_i;
  logic [31:0] rdata_o;
  logic        bad_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  lvt_regbank u_lvt_regbank (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmc_cap_i (cmc_cap_i),
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .bad_o     (bad_o)
  );

  function automatic logic [11:0] ent_addr(input int i);
    return (i == 6) ? 12'h2F0 : 12'(12'h320 + 16 * i);
  endfunction

  function automatic logic [31:0] exp_mask(input int i);
    case (i)
      0:       return 32'h0007_00FF;
      2, 6:    return 32'h0001_07FF;
      3, 4:    return 32'h0001_A7FF;
      default: return 32'h0001_00FF;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic cap);
    @(negedge clk);
    rst_n = 1'b0; req_i = 1'b0; we_i = 1'b0; addr_i = '0; wdata_i = '0;
    cmc_cap_i = cap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d, output logic b);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
    b = bad_o;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d, output logic b);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk);
    req_i = 1'b0;
    d = rdata_o; b = bad_o;
  endtask

  task automatic t_reset_R1;
    logic [31:0] d; logic b;
    do_reset(1'b1);
    chk("R1 bad_o after reset", 32'(bad_o), 32'h0);
    for (int i = 0; i < 7; i++) begin
      bus_rd(ent_addr(i), d, b);
      chk($sformatf("R1 entry %0d reset value", i), d, 32'h0001_0000);
    end
    bus_rd(12'h0F0, d, b);
    chk("R1 spurious reset", d, 32'h0);
  endtask

  task automatic t_version_R2;
    logic [31:0] d; logic b;
    bus_rd(12'h030, d, b);
    chk("R2 version with capability", d, 32'h0006_0014);
    bus_wr(12'h030, 32'hFFFF_FFFF, b);
    bus_rd(12'h030, d, b);
    chk("R2 version after write", d, 32'h0006_0014);
  endtask

  task automatic t_masks_R4;
    logic [31:0] d; logic b;
    bus_wr(12'h0F0, 32'h0000_01FF, b);
    for (int i = 0; i < 7; i++) begin
      bus_wr(ent_addr(i), 32'hFFFF_FFFF, b);
      bus_rd(ent_addr(i), d, b);
      chk($sformatf("R4 entry %0d writable mask", i), d, exp_mask(i));
    end
  endtask

  task automatic t_addr_map_R3;
    logic [31:0] d; logic b;
    for (int i = 0; i < 7; i++) bus_wr(ent_addr(i), 32'h40 + 32'(i), b);
    for (int i = 0; i < 7; i++) begin
      bus_rd(ent_addr(i), d, b);
      chk($sformatf("R3 entry %0d at its offset", i), d, 32'h40 + 32'(i));
    end
  endtask

  task automatic t_svr_disable_R6;
    logic [31:0] d; logic b;
    bus_wr(12'h0F0, 32'h0000_00FF, b);
    for (int i = 0; i < 7; i++) begin
      bus_rd(ent_addr(i), d, b);
      chk($sformatf("R6 entry %0d masked, rest kept", i), d, 32'h0001_0040 + 32'(i));
    end
  endtask

  task automatic t_disabled_write_R5;
    logic [31:0] d; logic b;
    bus_wr(12'h320, 32'h0000_0031, b);
    bus_rd(12'h320, d, b);
    chk("R5 write while disabled forces mask", d, 32'h0001_0031);
    bus_wr(12'h0F0, 32'h0000_0100, b);
    bus_wr(12'h320, 32'h0000_0032, b);
    bus_rd(12'h320, d, b);
    chk("R5 write while enabled keeps mask clear", d, 32'h0000_0032);
  endtask

  task automatic t_svr_R11;
    logic [31:0] d; logic b;
    bus_wr(12'h0F0, 32'h0000_01A5, b);
    bus_rd(12'h0F0, d, b);
    chk("R11 spurious readback", d, 32'h0000_01A5);
    bus_rd(12'h340, d, b);
    chk("R11 enabling leaves entries", d, 32'h0001_0042);
    bus_wr(12'h0F0, 32'hFFFF_FFFF, b);
    bus_rd(12'h0F0, d, b);
    chk("R11 spurious keeps 9 bits", d, 32'h0000_01FF);
  endtask

  task automatic t_unmapped_R8;
    logic [31:0] d; logic b;
    bus_rd(12'h3F0, d, b);
    chk("R8 unmapped read data", d, 32'h0);
    chk("R8 unmapped read flag", 32'(b), 32'h1);
    @(negedge clk);
    chk("R9 flag lasts one cycle", 32'(bad_o), 32'h0);
    bus_rd(12'h324, d, b);
    chk("R8 misaligned read flag", 32'(b), 32'h1);
    bus_wr(12'h380, 32'hFFFF_FFFF, b);
    chk("R8 unmapped write flag", 32'(b), 32'h1);
    bus_wr(12'h374, 32'h0000_00AA, b);
    chk("R8 misaligned write flag", 32'(b), 32'h1);
    bus_rd(12'h370, d, b);
    chk("R8 error entry untouched", d, 32'h0001_0045);
    chk("R9 valid read no flag", 32'(b), 32'h0);
  endtask

  task automatic t_cap_frozen_R10;
    logic [31:0] d; logic b;
    cmc_cap_i = 1'b0;
    repeat (2) @(negedge clk);
    bus_rd(12'h030, d, b);
    chk("R10 version after cap drop", d, 32'h0006_0014);
    bus_wr(12'h2F0, 32'h0000_0077, b);
    chk("R10 cmc write still accepted", 32'(b), 32'h0);
    bus_rd(12'h2F0, d, b);
    chk("R10 cmc readback", d, 32'h0000_0077);
  endtask

  task automatic t_cmc_absent_R7;
    logic [31:0] d; logic b;
    do_reset(1'b0);
    cmc_cap_i = 1'b1;
    bus_rd(12'h030, d, b);
    chk("R2 version without capability", d, 32'h0005_0014);
    bus_wr(12'h0F0, 32'h0000_0100, b);
    bus_wr(12'h2F0, 32'h0000_0055, b);
    chk("R7 absent cmc write refused", 32'(b), 32'h1);
    bus_rd(12'h2F0, d, b);
    chk("R7 absent cmc read data", d, 32'h0);
    chk("R7 absent cmc read flag", 32'(b), 32'h1);
    bus_rd(12'h370, d, b);
    chk("R7 error entry untouched", d, 32'h0001_0000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmc_cap_i = 1'b1; req_i = 1'b0; we_i = 1'b0;
    addr_i = '0; wdata_i = '0;
    t_reset_R1();
    t_version_R2();
    t_masks_R4();
    t_addr_map_R3();
    t_svr_disable_R6();
    t_disabled_write_R5();
    t_svr_R11();
    t_unmapped_R8();
    t_cap_frozen_R10();
    t_cmc_absent_R7();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule